// File: doc/BRIEF.md
# SCSI Controller Command Register Interface

This block is the byte-wide register slave of a simplified SCSI bus controller. A host reaches sixteen byte addresses through a single-cycle bus with separate read and write strobes. At several addresses a read returns controller status while a write reaches a separate setup register. The slave holds the status, interrupt-reason, sequence-step and FIFO-flags registers, a group of configuration registers and a 16-entry programmed-I/O byte FIFO. It turns each byte written to the command address into a chip-level action.

The bus signalling, the target devices and the DMA datapath lie outside the block. Selection commands only check a target-presence bitmap input at the index held in the target-ID setup register. A single level interrupt line follows the interrupt-pending bit of the status register. Reading the interrupt-reason register acknowledges the interrupt and clears the error bits.

Top module: `scsi_cmd_regs`

## Requirements
- R1: After reset, irq_o is low and these addresses read as follows: status (4) 0x00, interrupt reason (5) 0x00, FIFO flags (7) 0x00, command (3) 0x00, configuration 1 (8) 0x07, counter-high/ID (14) 0x04. A write to address 6 leaves the sequence-step readback unchanged. Addresses 9 and 10 always read 0x00, whatever was written to them.
- R2: Bytes written to address 2 are read back from address 2 in write order. Address 7 reads the number of bytes held. A read of address 2 when the FIFO is empty returns 0x00 and changes nothing. When a read leaves the FIFO empty, both FIFO pointers return to zero.
- R3: A write to address 2 while the FIFO holds 15 bytes drops the byte, leaves the count at 15 and sets status bit 6.
- R4: Status bit 7 is the interrupt-pending flag, and irq_o is high exactly while it is set. Commands that raise an interrupt set it.
- R5: A read of address 5 returns the current interrupt reason and leaves that register unchanged. It clears status bits 7, 6 and 5 and drops irq_o.
- R6: Command 0x03 (bus reset) loads reason 0x80. It raises the interrupt only while bit 6 of configuration 1 is clear.
- R7: Command 0x02 (chip reset) restores every register to its reset value, empties the FIFO, clears the sticky error bit and drops irq_o.
- R8: Command 0x01 (flush) loads reason 0x08 and clears the sequence step (address 6). It empties the FIFO, so flags read 0, and it leaves irq_o unchanged.
- R9: Writes to addresses 0 and 1 load setup bytes and clear status bit 4. The readback of addresses 0 and 1 takes the setup values only when a known command with bit 7 set (DMA) is written.
- R10: Command 0x42 or 0x43 with the target's presence bit clear sets status to 0x80, keeping bit 3 if it was set. It loads reason 0x20, sets the sequence step to 0 and empties the FIFO.
- R11: Command 0x42 with the target present gives reason 0x18, step 4 and an interrupt. Command 0x43 with the target present also sets status bit 4 and phase 2 and leaves a command pending. A following command 0x10 (transfer information) completes the pending command with reason 0x18, step 4 and an interrupt. Command 0x10 with nothing pending clears bit 4 and raises nothing.
- R12: Without DMA, command 0x11 loads two 0x00 bytes into the FIFO, sets reason 0x08, sets status phase bits 2:0 to 7 and raises the interrupt. Without DMA, command 0x12 loads the same two bytes, sets reason 0x20 and step 0 and raises the interrupt. With DMA, command 0x12 leaves the FIFO alone and sets status bit 4 and phase 3.
- R13: A command byte whose low seven bits are not a known code sets sticky status bit 3. That bit is cleared only by reset. The byte changes no other readable state, including the command readback.
- R14: Command 0x44 (enable selection) clears the interrupt-reason register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per access |
| re_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data for addr_i, valid before the strobe's edge |
| target_present_i | input | 8 | Presence bitmap indexed by target ID |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties assume that the host never asserts the read and write strobes in the same cycle, since the read side effects and the register writes then compete for the status register. The properties also assume that the presence bitmap is steady around a selection command. The bench drives exactly one strobe per access, with idle cycles between accesses, and changes the bitmap only between commands. Random FIFO traffic is weighted towards writes so that the full and overrun boundary is reached many times. Interrupt-reason reads are mixed into that traffic, so the clearing of the error bit is exercised against a running model.

// File: rtl/scsi_cmd_regs_pkg.sv
package scsi_cmd_regs_pkg;
  localparam int unsigned DW = 8;

  // register addresses
  localparam logic [3:0] A_CNT_LO  = 4'd0;
  localparam logic [3:0] A_CNT_MID = 4'd1;
  localparam logic [3:0] A_FIFO    = 4'd2;
  localparam logic [3:0] A_CMD     = 4'd3;
  localparam logic [3:0] A_STAT    = 4'd4;  // write: target id
  localparam logic [3:0] A_RSN     = 4'd5;
  localparam logic [3:0] A_SEQ     = 4'd6;
  localparam logic [3:0] A_FLAGS   = 4'd7;
  localparam logic [3:0] A_CFG1    = 4'd8;
  localparam logic [3:0] A_CFG2    = 4'd11;
  localparam logic [3:0] A_CFG3    = 4'd12;
  localparam logic [3:0] A_AUX13   = 4'd13;
  localparam logic [3:0] A_CNT_HI  = 4'd14;
  localparam logic [3:0] A_AUX15   = 4'd15;

  // command codes (bits 6:0)
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIP_RST = 7'h02;
  localparam logic [6:0] OP_BUS_RST  = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_CMPL     = 7'h11;
  localparam logic [6:0] OP_MSG_OK   = 7'h12;
  localparam logic [6:0] OP_SET_ATN  = 7'h1A;
  localparam logic [6:0] OP_SEL      = 7'h42;
  localparam logic [6:0] OP_SEL_STOP = 7'h43;
  localparam logic [6:0] OP_EN_SEL   = 7'h44;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_FLUSH, ACT_CHIP_RST, ACT_BUS_RST, ACT_XFER, ACT_CMPL,
    ACT_MSG_OK, ACT_SEL, ACT_SEL_STOP, ACT_EN_SEL, ACT_BAD
  } act_e;

  // interrupt reasons
  localparam logic [7:0] RSN_DONE = 8'h08;
  localparam logic [7:0] RSN_SVC  = 8'h10;
  localparam logic [7:0] RSN_DISC = 8'h20;
  localparam logic [7:0] RSN_BRST = 8'h80;

  // status bits
  localparam int unsigned ST_INT  = 7;
  localparam int unsigned ST_GERR = 6;
  localparam int unsigned ST_PERR = 5;
  localparam int unsigned ST_TC   = 4;
  localparam int unsigned ST_BAD  = 3;

  localparam logic [7:0] CFG1_RST   = 8'h07;
  localparam logic [7:0] CNT_HI_RST = 8'h04;
  localparam int unsigned CFG1_NOIRQ_BIT = 6;
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_cmd_regs_pkg::*;
(
  input  logic [7:0] cmd_i,
  output act_e       act_o,
  output logic       dma_o
);
  assign dma_o = cmd_i[7];

  always_comb begin
    case (cmd_i[6:0])
      OP_NOP, OP_SET_ATN: act_o = ACT_NONE;
      OP_FLUSH:           act_o = ACT_FLUSH;
      OP_CHIP_RST:        act_o = ACT_CHIP_RST;
      OP_BUS_RST:         act_o = ACT_BUS_RST;
      OP_XFER:            act_o = ACT_XFER;
      OP_CMPL:            act_o = ACT_CMPL;
      OP_MSG_OK:          act_o = ACT_MSG_OK;
      OP_SEL:             act_o = ACT_SEL;
      OP_SEL_STOP:        act_o = ACT_SEL_STOP;
      OP_EN_SEL:          act_o = ACT_EN_SEL;
      default:            act_o = ACT_BAD;
    endcase
  end
endmodule

// File: rtl/scsi_pio_fifo.sv
module scsi_pio_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld_resp_i,  // load two zero bytes
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovr_o
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != LIMIT) && !clr_i && !ld_resp_i;
  assign pop_ok  = pop_i && (cnt_q != '0) && !clr_i && !ld_resp_i;
  assign ovr_o   = push_i && (cnt_q == LIMIT) && !clr_i && !ld_resp_i;
  assign head_o  = (cnt_q != '0) ? mem_q[rptr_q] : '0;
  assign cnt_o   = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 mem_q[i] <= '0;
      else if (ld_resp_i && i < 2) mem_q[i] <= '0;
      else if (push_ok && wptr_q == PW'(i)) mem_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0; wptr_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      rptr_q <= '0; wptr_q <= '0; cnt_q <= '0;
    end else if (ld_resp_i) begin
      rptr_q <= '0; wptr_q <= PW'(2); cnt_q <= CW'(2);
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      if (push_ok && !pop_ok) cnt_q <= cnt_q + 1'b1;
      if (pop_ok && !push_ok) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          rptr_q <= '0;
          wptr_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
  import scsi_cmd_regs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ID_W  = 3,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEQ_W = 3,
  localparam int unsigned NTGT = 1 << ID_W,
  localparam int unsigned FCW  = $clog2(DEPTH) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NTGT-1:0] target_present_i,
  output logic            irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, setup_q, setup_d;
  logic [DW-1:0]    cmd_q, cmd_d, stat_q, stat_d, rsn_q, rsn_d;
  logic [DW-1:0]    cfg1_q, cfg1_d, cfg2_q, cfg2_d, cfg3_q, cfg3_d;
  logic [DW-1:0]    aux13_q, aux13_d, cnthi_q, cnthi_d, aux15_q, aux15_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [ID_W-1:0]  tgt_q, tgt_d;
  logic             pend_q, pend_d;

  act_e             act;
  logic             cmd_dma, wr_cmd, cmd_ok, chip_rst, tgt_here;
  logic             f_clr, f_ld, f_push, f_pop, f_ovr;
  logic [DW-1:0]    f_head;
  logic [FCW-1:0]   f_cnt;

  scsi_cmd_decode u_dec (.cmd_i(wdata_i), .act_o(act), .dma_o(cmd_dma));

  assign wr_cmd   = we_i && (addr_i == A_CMD);
  assign cmd_ok   = wr_cmd && (act != ACT_BAD);
  assign chip_rst = cmd_ok && (act == ACT_CHIP_RST);
  assign tgt_here = target_present_i[tgt_q];
  assign f_push   = we_i && (addr_i == A_FIFO);
  assign f_pop    = re_i && (addr_i == A_FIFO);
  assign f_clr    = cmd_ok && (act inside {ACT_FLUSH, ACT_CHIP_RST, ACT_SEL, ACT_SEL_STOP});
  assign f_ld     = cmd_ok && !cmd_dma && (act inside {ACT_CMPL, ACT_MSG_OK});

  scsi_pio_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
    .clk_i, .rst_ni, .clr_i(f_clr), .ld_resp_i(f_ld), .push_i(f_push),
    .din_i(wdata_i), .pop_i(f_pop), .head_o(f_head), .cnt_o(f_cnt), .ovr_o(f_ovr)
  );

  always_comb begin
    cnt_d = cnt_q; setup_d = setup_q; cmd_d = cmd_q; stat_d = stat_q; rsn_d = rsn_q;
    cfg1_d = cfg1_q; cfg2_d = cfg2_q; cfg3_d = cfg3_q; aux13_d = aux13_q;
    cnthi_d = cnthi_q; aux15_d = aux15_q; seq_d = seq_q; tgt_d = tgt_q; pend_d = pend_q;

    // acknowledge on reason read
    if (re_i && addr_i == A_RSN) begin
      stat_d[ST_INT] = 1'b0; stat_d[ST_GERR] = 1'b0; stat_d[ST_PERR] = 1'b0;
    end

    if (we_i) begin
      case (addr_i)
        A_CNT_LO:  begin setup_d[7:0]  = wdata_i; stat_d[ST_TC] = 1'b0; end
        A_CNT_MID: begin setup_d[15:8] = wdata_i; stat_d[ST_TC] = 1'b0; end
        A_STAT:    tgt_d   = wdata_i[ID_W-1:0];
        A_CFG1:    cfg1_d  = wdata_i;
        A_CFG2:    cfg2_d  = wdata_i;
        A_CFG3:    cfg3_d  = wdata_i;
        A_AUX13:   aux13_d = wdata_i;
        A_CNT_HI:  cnthi_d = wdata_i;
        A_AUX15:   aux15_d = wdata_i;
        default: ;
      endcase
    end

    if (f_ovr) stat_d[ST_GERR] = 1'b1;

    if (wr_cmd && act == ACT_BAD) stat_d[ST_BAD] = 1'b1;

    if (cmd_ok) begin
      cmd_d = wdata_i;
      if (cmd_dma) cnt_d = setup_q;
      case (act)
        ACT_FLUSH: begin rsn_d = RSN_DONE; seq_d = '0; end
        ACT_BUS_RST: begin
          rsn_d = RSN_BRST;
          if (!cfg1_q[CFG1_NOIRQ_BIT]) stat_d[ST_INT] = 1'b1;
        end
        ACT_XFER: begin
          stat_d[ST_TC] = 1'b0;
          if (pend_q) begin
            pend_d = 1'b0; rsn_d = RSN_DONE | RSN_SVC;
            seq_d = SEQ_W'(4); stat_d[ST_INT] = 1'b1;
          end
        end
        ACT_CMPL: begin
          rsn_d = RSN_DONE; stat_d[2:0] = 3'd7; stat_d[ST_INT] = 1'b1;
          if (cmd_dma) stat_d[ST_TC] = 1'b1;
        end
        ACT_MSG_OK: begin
          rsn_d = RSN_DISC; seq_d = '0; stat_d[ST_INT] = 1'b1;
          if (cmd_dma) begin stat_d[ST_TC] = 1'b1; stat_d[2:0] = 3'd3; end
        end
        ACT_SEL, ACT_SEL_STOP: begin
          if (!tgt_here) begin
            stat_d = stat_q & (DW'(1) << ST_BAD);
            stat_d[ST_INT] = 1'b1;
            rsn_d = RSN_DISC; seq_d = '0; pend_d = 1'b0;
          end else begin
            rsn_d = RSN_DONE | RSN_SVC; seq_d = SEQ_W'(4); stat_d[ST_INT] = 1'b1;
            pend_d = (act == ACT_SEL_STOP);
            if (act == ACT_SEL_STOP) begin stat_d[ST_TC] = 1'b1; stat_d[2:0] = 3'd2; end
          end
        end
        ACT_EN_SEL: rsn_d = '0;
        default: ;
      endcase
    end

    if (chip_rst) begin
      cnt_d = '0; setup_d = '0; cmd_d = '0; stat_d = '0; rsn_d = '0;
      cfg1_d = CFG1_RST; cfg2_d = '0; cfg3_d = '0; aux13_d = '0;
      cnthi_d = CNT_HI_RST; aux15_d = '0; seq_d = '0; tgt_d = '0; pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; setup_q <= '0; cmd_q <= '0; stat_q <= '0; rsn_q <= '0;
      cfg1_q <= CFG1_RST; cfg2_q <= '0; cfg3_q <= '0; aux13_q <= '0;
      cnthi_q <= CNT_HI_RST; aux15_q <= '0; seq_q <= '0; tgt_q <= '0; pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; setup_q <= setup_d; cmd_q <= cmd_d; stat_q <= stat_d; rsn_q <= rsn_d;
      cfg1_q <= cfg1_d; cfg2_q <= cfg2_d; cfg3_q <= cfg3_d; aux13_q <= aux13_d;
      cnthi_q <= cnthi_d; aux15_q <= aux15_d; seq_q <= seq_d; tgt_q <= tgt_d; pend_q <= pend_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_CNT_LO:  rdata_o = cnt_q[7:0];
      A_CNT_MID: rdata_o = cnt_q[15:8];
      A_FIFO:    rdata_o = f_head;
      A_CMD:     rdata_o = cmd_q;
      A_STAT:    rdata_o = stat_q;
      A_RSN:     rdata_o = rsn_q;
      A_SEQ:     rdata_o = DW'(seq_q);
      A_FLAGS:   rdata_o = DW'(f_cnt);
      A_CFG1:    rdata_o = cfg1_q;
      A_CFG2:    rdata_o = cfg2_q;
      A_CFG3:    rdata_o = cfg3_q;
      A_AUX13:   rdata_o = aux13_q;
      A_CNT_HI:  rdata_o = cnthi_q;
      A_AUX15:   rdata_o = aux15_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = stat_q[ST_INT];
endmodule

// File: rtl/scsi_cmd_regs_chk.sv
module scsi_cmd_regs_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          we_i,
  input logic          re_i,
  input logic          irq_o,
  input logic [7:0]    stat_i,
  input logic [7:0]    cmd_i,
  input logic [7:0]    cfg1_i,
  input logic [CW-1:0] fcnt_i,
  input logic [PW-1:0] frptr_i,
  input logic [PW-1:0] fwptr_i
);
  function automatic logic known_op(input logic [6:0] op);
    return op inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12,
                      7'h1A, 7'h42, 7'h43, 7'h44};
  endfunction

  logic wr_c, rd_rsn;
  assign wr_c   = we_i && !re_i && addr_i == 4'd3;
  assign rd_rsn = re_i && !we_i && addr_i == 4'd5;

  AST_RSN_READ_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsn |=> !irq_o && stat_i[6:5] == 2'b00);  // R5
  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == stat_i[7]);  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_i <= CW'(DEPTH - 1));  // R3
  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !re_i && addr_i == 4'd2 && fcnt_i == CW'(DEPTH - 1))
      |=> stat_i[6] && fcnt_i == CW'(DEPTH - 1));  // R3
  AST_EMPTY_PTRS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_i == '0 |-> frptr_i == '0 && fwptr_i == '0);  // R2
  AST_BUSRST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && wdata_i[6:0] == 7'h03 && cfg1_i[6] && !irq_o) |=> !irq_o);  // R6
  AST_BAD_CMD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && !known_op(wdata_i[6:0])) |=> $stable(cmd_i) && stat_i[3]);  // R13
  AST_CHIP_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && wdata_i[6:0] == 7'h02) |=> !irq_o && cfg1_i == 8'h07 && fcnt_i == '0);  // R7
endmodule

bind scsi_cmd_regs scsi_cmd_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .re_i(re_i), .irq_o(irq_o), .stat_i(stat_q), .cmd_i(cmd_q),
  .cfg1_i(cfg1_q), .fcnt_i(u_fifo.cnt_q), .frptr_i(u_fifo.rptr_q),
  .fwptr_i(u_fifo.wptr_q)
);

// File: tb/test_scsi_cmd_regs.sv
module test_scsi_cmd_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, present = 8'h00;
  logic       irq;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scsi_cmd_regs i_scsi_cmd_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .target_present_i(present), .irq_o(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    chk(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  // bench model: status after FIFO traffic only
  function automatic logic [7:0] exp_stat(input bit gerr);
    return gerr ? 8'h40 : 8'h00;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] v, b;
    bit gerr;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values and read/write split
    chk_irq("R1 irq", 1'b0);
    chk_rd("R1 status", 4'd4, 8'h00);
    chk_rd("R1 reason", 4'd5, 8'h00);
    chk_rd("R1 flags", 4'd7, 8'h00);
    chk_rd("R1 cmd", 4'd3, 8'h00);
    chk_rd("R1 cfg1", 4'd8, 8'h07);
    chk_rd("R1 cnt_hi", 4'd14, 8'h04);
    wr(4'd6, 8'hFF);
    chk_rd("R1 seq write-only", 4'd6, 8'h00);
    wr(4'd9, 8'hAA); wr(4'd10, 8'h55);
    chk_rd("R1 addr9", 4'd9, 8'h00);
    chk_rd("R1 addr10", 4'd10, 8'h00);

    // R2 R3 random FIFO traffic against a queue model
    gerr = 1'b0;
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 6) begin
        b = 8'($urandom());
        wr(4'd2, b);
        if (q.size() == 15) gerr = 1'b1;
        else q.push_back(b);
      end else if (r < 9) begin
        rd(4'd2, v);
        chk("R2 fifo data", v, (q.size() > 0) ? q.pop_front() : 8'h00);
      end else begin
        rd(4'd5, v);
        chk("R5 reason during traffic", v, 8'h00);
        gerr = 1'b0;
      end
      if (i % 8 == 7) begin
        chk_rd("R2 flags", 4'd7, 8'(q.size()));
        chk_rd("R3 status", 4'd4, exp_stat(gerr));
      end
    end
    while (q.size() > 0) begin
      rd(4'd2, v);
      chk("R2 drain", v, q.pop_front());
    end
    rd(4'd5, v);

    // R3 directed full boundary
    for (int i = 0; i < 15; i++) wr(4'd2, 8'(8'h30 + i));
    chk_rd("R3 flags full", 4'd7, 8'd15);
    chk_rd("R3 no error yet", 4'd4, 8'h00);
    wr(4'd2, 8'hEE);
    chk_rd("R3 flags after overrun", 4'd7, 8'd15);
    chk_rd("R3 gross error", 4'd4, 8'h40);
    for (int i = 0; i < 15; i++) chk_rd("R3 order kept", 4'd2, 8'(8'h30 + i));
    chk_rd("R2 empty read", 4'd2, 8'h00);
    chk_rd("R2 empty flags", 4'd7, 8'h00);
    wr(4'd2, 8'hA1);
    chk_rd("R2 restart after empty", 4'd2, 8'hA1);
    chk_rd("R5 clears error", 4'd5, 8'h00);
    chk_rd("R5 status cleared", 4'd4, 8'h00);

    // R6 R5 R4 bus reset and acknowledge
    wr(4'd3, 8'h03);
    chk_irq("R4 irq raised", 1'b1);
    chk_rd("R4 pending bit", 4'd4, 8'h80);
    chk_rd("R5 reason value", 4'd5, 8'h80);
    chk_irq("R5 irq dropped", 1'b0);
    chk_rd("R5 status after ack", 4'd4, 8'h00);
    chk_rd("R5 reason kept", 4'd5, 8'h80);
    wr(4'd8, 8'h47);
    wr(4'd3, 8'h03);
    chk_irq("R6 masked", 1'b0);
    chk_rd("R6 reason masked", 4'd5, 8'h80);
    wr(4'd8, 8'h07);

    // R8 flush
    wr(4'd2, 8'h11); wr(4'd2, 8'h22); wr(4'd2, 8'h33);
    wr(4'd3, 8'h01);
    chk_irq("R8 no irq", 1'b0);
    chk_rd("R8 flags", 4'd7, 8'h00);
    chk_rd("R8 seq", 4'd6, 8'h00);
    chk_rd("R8 reason", 4'd5, 8'h08);

    // R9 counter reload
    wr(4'd0, 8'h34); wr(4'd1, 8'h12);
    chk_rd("R9 no reload yet", 4'd0, 8'h00);
    wr(4'd3, 8'h80);
    chk_rd("R9 lo", 4'd0, 8'h34);
    chk_rd("R9 mid", 4'd1, 8'h12);
    chk_rd("R9 cmd readback", 4'd3, 8'h80);

    // R10 absent target
    present = 8'b0000_0100;
    wr(4'd4, 8'h03);
    wr(4'd3, 8'h42);
    chk_irq("R10 irq", 1'b1);
    chk_rd("R10 status", 4'd4, 8'h80);
    chk_rd("R10 reason", 4'd5, 8'h20);
    chk_rd("R10 seq", 4'd6, 8'h00);

    // R11 present target
    wr(4'd4, 8'h02);
    wr(4'd2, 8'h99);
    wr(4'd3, 8'h42);
    chk_rd("R11 status", 4'd4, 8'h80);
    chk_rd("R11 fifo emptied", 4'd7, 8'h00);
    chk_rd("R11 reason", 4'd5, 8'h18);
    chk_rd("R11 seq", 4'd6, 8'h04);
    chk_irq("R11 acked", 1'b0);
    wr(4'd3, 8'h43);
    chk_rd("R11 stop status", 4'd4, 8'h92);
    chk_rd("R11 stop reason", 4'd5, 8'h18);
    wr(4'd0, 8'h00);
    chk_rd("R9 count write clears bit4", 4'd4, 8'h02);
    wr(4'd3, 8'h10);
    chk_irq("R11 xfer completes", 1'b1);
    chk_rd("R11 xfer status", 4'd4, 8'h82);
    chk_rd("R11 xfer reason", 4'd5, 8'h18);
    chk_rd("R11 xfer seq", 4'd6, 8'h04);
    wr(4'd3, 8'h10);
    chk_irq("R11 xfer idle", 1'b0);
    chk_rd("R11 xfer idle status", 4'd4, 8'h02);

    // R12 response commands
    wr(4'd3, 8'h11);
    chk_irq("R12 cmpl irq", 1'b1);
    chk_rd("R12 cmpl status", 4'd4, 8'h87);
    chk_rd("R12 cmpl flags", 4'd7, 8'h02);
    chk_rd("R12 cmpl byte0", 4'd2, 8'h00);
    chk_rd("R12 cmpl byte1", 4'd2, 8'h00);
    chk_rd("R12 cmpl reason", 4'd5, 8'h08);
    wr(4'd3, 8'h12);
    chk_irq("R12 msg irq", 1'b1);
    chk_rd("R12 msg flags", 4'd7, 8'h02);
    chk_rd("R12 msg reason", 4'd5, 8'h20);
    chk_rd("R12 msg seq", 4'd6, 8'h00);
    wr(4'd3, 8'h92);
    chk_rd("R12 msg dma status", 4'd4, 8'h93);
    chk_rd("R12 msg dma flags", 4'd7, 8'h02);
    rd(4'd5, v);

    // R13 unknown command
    wr(4'd3, 8'h27);
    chk_rd("R13 cmd kept", 4'd3, 8'h92);
    chk_rd("R13 sticky bit", 4'd4, 8'h1B);
    chk_irq("R13 no irq", 1'b0);
    chk_rd("R13 flags kept", 4'd7, 8'h02);
    chk_rd("R13 reason kept", 4'd5, 8'h20);
    chk_rd("R13 survives ack", 4'd4, 8'h1B);

    // R14 enable selection
    wr(4'd3, 8'h44);
    chk_rd("R14 reason cleared", 4'd5, 8'h00);

    // R7 chip reset
    wr(4'd11, 8'h55); wr(4'd14, 8'h9C);
    wr(4'd3, 8'h03);
    chk_irq("R7 pre irq", 1'b1);
    wr(4'd3, 8'h02);
    chk_irq("R7 irq", 1'b0);
    chk_rd("R7 status", 4'd4, 8'h00);
    chk_rd("R7 cfg1", 4'd8, 8'h07);
    chk_rd("R7 cnt_hi", 4'd14, 8'h04);
    chk_rd("R7 cfg2", 4'd11, 8'h00);
    chk_rd("R7 flags", 4'd7, 8'h00);
    chk_rd("R7 cmd", 4'd3, 8'h00);
    chk_rd("R7 cnt lo", 4'd0, 8'h00);
    chk_rd("R7 reason", 4'd5, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule